// File: doc/BRIEF.md
# Packed SIMD Lane Adder with Byte Select

This block is a purely combinational datapath that treats a 32-bit word as either four byte lanes or two halfword lanes and performs an add or subtract in every lane at once. Each operation comes in six arithmetic flavours: wrapping, clamping and averaging, each in a signed and an unsigned form. For halfword lanes there are also two crossed forms. These pair each half of operand A with the opposite half of operand B, adding on one side and subtracting on the other.

Wrapping operations also produce a per-byte "greater or equal" flag vector. The surrounding pipeline stores this vector and feeds it back on `flags_in`. A later select operation uses it to merge A and B byte by byte. The block also computes a sum of absolute byte differences, with an optional accumulator term. Holding the stored flags is left to the caller. The block only computes the next flag value and returns it on `flags_out`.

Top module: `simd_addsub_sel`

## Requirements
- R1: `op_code` is decoded as bit 5 = unsigned, bits 4:3 = flavour (0 wrap, 1 clamp, 2 average, 3 misc), bit 2 = halfword lanes, bits 1:0 = kind (0 add, 1 subtract, 2 cross add-high/sub-low, 3 cross sub-high/add-low). With all inputs zero, the result is 0 and `flags_out` is 4'b1111.
- R2: The wrap flavour returns each lane's sum or difference modulo the lane width. The signed and unsigned forms give the same result bits.
- R3: The clamp flavour limits the result to [-2^(w-1), 2^(w-1)-1] for signed lanes and to [0, 2^w-1] for unsigned lanes, where w is the lane width.
- R4: The average flavour computes the exact sum or difference at full precision and then shifts it right by one. The shift is arithmetic for signed lanes and logical for unsigned lanes, so the result rounds toward minus infinity.
- R5: When bit 2 is set, the add and subtract kinds operate on two independent 16-bit lanes with the same flavours as byte lanes.
- R6: Kind 2 always uses halfword lanes, whatever bit 2 says. It gives high = A.hi + B.lo and low = A.lo - B.hi.
- R7: Kind 3 always uses halfword lanes. It gives high = A.hi - B.lo and low = A.lo + B.hi.
- R8: In the signed wrap flavour, each lane's flag is 1 when the exact (unwrapped) result is greater than or equal to zero.
- R9: In the unsigned wrap flavour, a lane's flag is 1 on carry-out for an add and on no-borrow for a subtract. For halfword lanes, both flag bits covering a half carry that half's flag.
- R10: The clamp, average and misc flavours return `flags_in` unchanged on `flags_out`.
- R11: Misc kind 0 (select) takes byte i from A when `flags_in[i]` is 1 and from B otherwise.
- R12: Misc kind 1 returns the sum of the four unsigned byte absolute differences |A[i]-B[i]|. Misc kind 2 returns that sum plus `acc`, modulo 2^32.
- R13: Misc kind 3 returns a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Operation selector, fields as in R1 |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| acc | input | 32 | Accumulator term for the absolute-difference sum |
| flags_in | input | 4 | Stored per-byte greater-or-equal vector |
| result | output | 32 | Packed lane result |
| flags_out | output | 4 | Next flag vector |

## Verification
The hardest conditions to reach from the ports are clamping in the crossed forms, where one half saturates high and the other saturates low in the same operation. The per-half flag duplication after an unsigned halfword carry is similarly hard to reach. Uniform random operands rarely land there. The stimulus therefore combines directed operands placed right at the lane boundaries with a random phase that draws operands mostly from edge values (0, 0x7F/0x80, 0xFF patterns per lane). A behavioural integer model is compared with both outputs on every clock.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_ASX = 2'd2,
    K_SAX = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    F_WRAP  = 2'd0,
    F_CLAMP = 2'd1,
    F_AVG   = 2'd2,
    F_MISC  = 2'd3
  } flav_e;

  typedef struct packed {
    logic  uns;
    flav_e flav;
    logic  wide;
    kind_e kind;
  } simd_op_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         uns,
  input  flav_e        flav,
  output logic [W-1:0] res,
  output logic         ge,
  output logic         clamp_evt
);
  localparam int XW = W + 2;
  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic [XW-1:0] widen(input logic [W-1:0] v, input logic u);
    return u ? {2'b00, v} : {{2{v[W-1]}}, v};
  endfunction

  function automatic logic [W-1:0] clamp_val(input logic [XW-1:0] f, input logic u,
                                             output logic hit);
    logic neg, over, under;
    neg   = f[XW-1];
    over  = u ? (!neg && f[W]) : (!neg && (f[W:W-1] != 2'b00));
    under = u ? neg : (neg && (f[W:W-1] != 2'b11));
    hit   = over || under;
    if (over)       return u ? UMAX : SMAX;
    else if (under) return u ? '0 : SMIN;
    else            return f[W-1:0];
  endfunction

  logic [XW-1:0] full;
  logic [W-1:0]  sat_v;
  logic          sat_hit;

  always_comb begin
    full  = sub ? (widen(a, uns) - widen(b, uns)) : (widen(a, uns) + widen(b, uns));
    sat_v = clamp_val(full, uns, sat_hit);
    ge    = (uns && !sub) ? full[W] : !full[XW-1];
    unique case (flav)
      F_CLAMP: res = sat_v;
      F_AVG:   res = full[W:1];
      default: res = full[W-1:0];
    endcase
    clamp_evt = (flav == F_CLAMP) && sat_hit;
  end

  always_comb begin
    // R3
    if (clamp_evt) begin
      sat_bound_chk: assert (uns ? (res == UMAX || res == '0) : (res == SMAX || res == SMIN));
    end
    // R9
    if (flav == F_WRAP && uns && !sub) begin
      carry_flag_chk: assert (ge == (res < a));
    end
    // R4
    if (flav == F_AVG && !sub) begin
      if (uns) begin
        avg_mid_chk: assert (res >= ((a < b) ? a : b) && res <= ((a < b) ? b : a));
      end else begin
        avg_smid_chk: assert ($signed(res) >= (($signed(a) < $signed(b)) ? $signed(a) : $signed(b))
                           && $signed(res) <= (($signed(a) < $signed(b)) ? $signed(b) : $signed(a)));
      end
    end
  end

endmodule

// File: rtl/simd_absdiff_sum.sv
module simd_absdiff_sum #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] acc,
  input  logic          use_acc,
  output logic [DW-1:0] sum
);
  localparam int NB = DW / 8;
  localparam logic [DW-1:0] MAX_SAD = DW'(NB * 255);

  function automatic logic [7:0] absdiff(input logic [7:0] x, input logic [7:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic [7:0] d [NB];

  for (genvar i = 0; i < NB; i++) begin : g_diff
    assign d[i] = absdiff(a[8*i +: 8], b[8*i +: 8]);
  end

  always_comb begin
    sum = use_acc ? acc : '0;
    for (int i = 0; i < NB; i++) sum = sum + {{(DW-8){1'b0}}, d[i]};
  end

  always_comb begin
    // R12
    sad_range_chk: assert ((sum - (use_acc ? acc : '0)) <= MAX_SAD);
  end

endmodule

// File: rtl/simd_byte_sel.sv
module simd_byte_sel #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW/8-1:0] pick_a,
  output logic [DW-1:0]   y
);
  localparam int NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign y[8*i +: 8] = pick_a[i] ? a[8*i +: 8] : b[8*i +: 8];

    always_comb begin
      // R11
      if (a[8*i +: 8] != b[8*i +: 8]) begin
        sel_src_chk: assert ((y[8*i +: 8] == a[8*i +: 8]) == pick_a[i]);
      end
    end
  end

endmodule

// File: rtl/simd_addsub_sel.sv
module simd_addsub_sel
  import simd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [5:0]      op_code,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [DW-1:0]   acc,
  input  logic [DW/8-1:0] flags_in,
  output logic [DW-1:0]   result,
  output logic [DW/8-1:0] flags_out
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  simd_op_t opf;
  assign opf = simd_op_t'(op_code);

  logic            use_half;
  logic [DW-1:0]   byte_res, half_res, sel_res, sad_res;
  logic [NB-1:0]   byte_ge, half_ge_dup;
  logic [NB-1:0]   byte_clamp;
  logic [NH-1:0]   half_ge, half_clamp;

  assign use_half = opf.wide || opf.kind[1];

  for (genvar i = 0; i < NB; i++) begin : g_b
    simd_lane #(.W(8)) u_lane (
      .a        (opa[8*i +: 8]),
      .b        (opb[8*i +: 8]),
      .sub      (opf.kind == K_SUB),
      .uns      (opf.uns),
      .flav     (opf.flav),
      .res      (byte_res[8*i +: 8]),
      .ge       (byte_ge[i]),
      .clamp_evt(byte_clamp[i])
    );
  end

  for (genvar j = 0; j < NH; j++) begin : g_h
    localparam bit IS_HI = (j % 2) == 1;
    logic        h_sub;
    logic [15:0] h_b;

    always_comb begin
      unique case (opf.kind)
        K_ADD:   h_sub = 1'b0;
        K_SUB:   h_sub = 1'b1;
        K_ASX:   h_sub = !IS_HI;
        default: h_sub = IS_HI;
      endcase
      h_b = opf.kind[1] ? opb[16*(j ^ 1) +: 16] : opb[16*j +: 16];
    end

    simd_lane #(.W(16)) u_lane (
      .a        (opa[16*j +: 16]),
      .b        (h_b),
      .sub      (h_sub),
      .uns      (opf.uns),
      .flav     (opf.flav),
      .res      (half_res[16*j +: 16]),
      .ge       (half_ge[j]),
      .clamp_evt(half_clamp[j])
    );

    assign half_ge_dup[2*j]   = half_ge[j];
    assign half_ge_dup[2*j+1] = half_ge[j];
  end

  simd_byte_sel #(.DW(DW)) u_sel (
    .a     (opa),
    .b     (opb),
    .pick_a(flags_in),
    .y     (sel_res)
  );

  simd_absdiff_sum #(.DW(DW)) u_sad (
    .a      (opa),
    .b      (opb),
    .acc    (acc),
    .use_acc(opf.kind == K_ASX),
    .sum    (sad_res)
  );

  always_comb begin
    if (opf.flav == F_MISC) begin
      unique case (opf.kind)
        K_ADD:   result = sel_res;
        K_SUB,
        K_ASX:   result = sad_res;
        default: result = '0;
      endcase
    end else begin
      result = use_half ? half_res : byte_res;
    end
    if (opf.flav == F_WRAP) flags_out = use_half ? half_ge_dup : byte_ge;
    else                    flags_out = flags_in;
  end

  always_comb begin
    // R9
    if (opf.flav == F_WRAP && use_half) begin
      for (int k = 0; k < NH; k++) begin
        pair_flag_chk: assert (flags_out[2*k] == flags_out[2*k+1]);
      end
    end
    // R3
    if (opf.flav != F_CLAMP) begin
      clamp_idle_chk: assert (byte_clamp == '0 && half_clamp == '0);
    end
  end

endmodule

// File: tb/sim_simd_addsub_sel.sv
module sim_simd_addsub_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_code = '0;
  logic [31:0] opa = '0, opb = '0, acc = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_addsub_sel u0 (
    .op_code(op_code), .opa(opa), .opb(opb), .acc(acc),
    .flags_in(flags_in), .result(result), .flags_out(flags_out)
  );

  function automatic logic [5:0] mk(int u, int fl, int wide, int k);
    return {u[0], fl[1:0], wide[0], k[1:0]};
  endfunction

  // behavioural reference: returns {flags, result}
  function automatic logic [35:0] model(logic [5:0] op, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] ac, logic [3:0] gi);
    bit u = op[5];
    int fl = int'(op[4:3]);
    int wide = int'(op[2]);
    int k = int'(op[1:0]);
    longint r = 0;
    logic [3:0] go = gi;
    if (fl == 3) begin
      if (k == 0) begin
        for (int i = 0; i < 4; i++) r |= longint'(gi[i] ? a[8*i +: 8] : b[8*i +: 8]) << (8*i);
      end else if (k == 1 || k == 2) begin
        for (int i = 0; i < 4; i++) begin
          longint x = a[8*i +: 8];
          longint y = b[8*i +: 8];
          r += (x > y) ? x - y : y - x;
        end
        if (k == 2) r += ac;
        r &= 64'hFFFF_FFFF;
      end
    end else begin
      int lw = (wide == 1 || k >= 2) ? 16 : 8;
      int n = 32 / lw;
      longint m = (64'd1 << lw) - 1;
      for (int i = 0; i < n; i++) begin
        longint x = (a >> (i*lw)) & m;
        int j = (k >= 2) ? (i ^ 1) : i;
        longint y = (b >> (j*lw)) & m;
        bit s = (k == 1) || (k == 2 && i % 2 == 0) || (k == 3 && i % 2 == 1);
        longint t, v;
        bit f;
        if (!u) begin
          if (x >= (m+1)/2) x -= m + 1;
          if (y >= (m+1)/2) y -= m + 1;
        end
        t = s ? x - y : x + y;
        f = (u && !s) ? (t > m) : (t >= 0);
        if (fl == 0) v = t;
        else if (fl == 2) v = t >>> 1;
        else begin
          longint lo = u ? 0 : -((m+1)/2);
          longint hi = u ? m : (m-1)/2;
          v = (t < lo) ? lo : (t > hi) ? hi : t;
        end
        r |= (v & m) << (i*lw);
        if (fl == 0) for (int q = 0; q < lw/8; q++) go[i*(lw/8) + q] = f;
      end
    end
    return {go, r[31:0]};
  endfunction

  task automatic check(string tag, bit ok, logic [35:0] got, logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h: actual flags=%b result=%h expected flags=%b result=%h",
               tag, op_code, opa, opb, got[35:32], got[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  // exp_r/exp_g < 0 means: take the model's value only
  task automatic run(string tag, logic [5:0] op, logic [31:0] a, logic [31:0] b,
                     logic [31:0] ac, logic [3:0] gi, longint exp_r, int exp_g);
    logic [35:0] mexp;
    logic [35:0] got;
    @(posedge clk);
    #1;
    op_code = op; opa = a; opb = b; acc = ac; flags_in = gi;
    @(negedge clk);
    mexp = model(op, a, b, ac, gi);
    got = {flags_out, result};
    if (exp_r >= 0) check(tag, result == exp_r[31:0], got, {mexp[35:32], exp_r[31:0]});
    if (exp_g >= 0) check(tag, flags_out == exp_g[3:0], got, {exp_g[3:0], mexp[31:0]});
    check(tag, got == mexp, got, mexp);
  endtask

  function automatic logic [31:0] edgy();
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      case ($urandom % 6)
        0: w[8*i +: 8] = 8'h00;
        1: w[8*i +: 8] = 8'h7F;
        2: w[8*i +: 8] = 8'h80;
        3: w[8*i +: 8] = 8'hFF;
        4: w[8*i +: 8] = 8'h01;
        default: w[8*i +: 8] = 8'($urandom);
      endcase
    end
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 idle state: all-zero inputs
    run("R1", 6'd0, 0, 0, 0, 0, 0, 4'hF);
    // R2 wrapping byte add, signed and unsigned
    run("R2", mk(0,0,0,0), 32'h87858381, 32'h08060402, 0, 0, 32'h8F8B8783, -1);
    run("R2", mk(1,0,0,0), 32'h07050301, 32'h08060402, 0, 0, 32'h0F0B0703, -1);
    run("R2", mk(1,0,0,1), 32'h0F0B0703, 32'h08060402, 0, 0, 32'h07050301, -1);
    // R3 clamping
    run("R3", mk(0,1,0,0), 32'h8085837F, 32'hFF060402, 0, 0, 32'h808B877F, -1);
    run("R3", mk(1,1,0,1), 32'h080B0702, 32'h0F060408, 0, 0, 32'h00050300, -1);
    // R4 averaging
    run("R4", mk(0,2,0,1), 32'h8F8B8783, 32'h08060402, 0, 0, 32'hC3C2C1C0, -1);
    run("R4", mk(1,2,0,1), 32'h0F0B0703, 32'h08060402, 0, 0, 32'h03020100, -1);
    // R5 halfword lanes
    run("R5", mk(0,1,1,0), 32'h80038000, 32'h00048002, 0, 0, 32'h80078000, -1);
    run("R5", mk(0,2,1,0), 32'h80038001, 32'h00040002, 0, 0, 32'hC003C001, -1);
    // R6 cross add-high / sub-low
    run("R6", mk(0,0,1,2), 32'h80078003, 32'h00040002, 0, 0, 32'h80097FFF, -1);
    run("R6", mk(0,1,1,2), 32'h80078003, 32'h00040002, 0, 0, 32'h80098000, -1);
    run("R6", mk(0,2,1,2), 32'h80078003, 32'h00040002, 0, 0, 32'hC004BFFF, -1);
    run("R6", mk(1,1,0,2), 32'hFFF80003, 32'h00040009, 0, 0, 32'hFFFF0000, -1);
    // R7 cross sub-high / add-low
    run("R7", mk(0,0,1,3), 32'h80038007, 32'h00020004, 0, 0, 32'h7FFF8009, -1);
    run("R7", mk(0,1,1,3), 32'h80038007, 32'h00020004, 0, 0, 32'h80008009, -1);
    // R8 signed flags
    run("R8", mk(0,0,0,0), 32'h80808080, 0, 0, 4'hF, 32'h80808080, 4'b0000);
    run("R8", mk(0,0,0,0), 32'h80808000, 0, 0, 0, 32'h80808000, 4'b0001);
    run("R8", mk(0,0,0,0), 32'h80800080, 0, 0, 0, 32'h80800080, 4'b0010);
    // R9 unsigned carry / no-borrow flags, halfword duplication
    run("R9", mk(1,0,1,0), 32'hFFFF0001, 32'h00010001, 0, 0, 32'h00000002, 4'b1100);
    run("R9", mk(1,0,0,1), 32'h05010300, 32'h04020300, 0, 0, 32'h01FF0000, 4'b1011);
    // R10 flags pass through for non-wrap flavours
    run("R10", mk(0,1,0,0), 32'h7F7F7F7F, 32'h01010101, 0, 4'b0101, 32'h7F7F7F7F, 4'b0101);
    run("R10", mk(1,2,1,1), 32'h00000000, 32'h00010001, 0, 4'b1001, -1, 4'b1001);
    // R11 select
    run("R11", mk(0,3,0,0), 32'h33221100, 32'h77665544, 0, 4'b0001, 32'h77665500, 4'b0001);
    run("R11", mk(0,3,0,0), 32'h33221100, 32'h77665544, 0, 4'b0010, 32'h77661144, 4'b0010);
    // R12 absolute-difference sum
    run("R12", mk(0,3,0,1), 32'h87858381, 32'h08060402, 32'h12345678, 0, 32'h000001FC, -1);
    run("R12", mk(0,3,0,2), 32'h87858381, 32'h08060402, 32'h00008000, 0, 32'h000081FC, -1);
    // R13 reserved misc code
    run("R13", mk(0,3,1,3), 32'hFFFFFFFF, 32'h12345678, 32'h1, 4'b1010, 0, 4'b1010);
    // random phase: all requirements against the model
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op = 6'($urandom);
      logic [31:0] a = ($urandom % 4 == 0) ? $urandom : edgy();
      logic [31:0] b = ($urandom % 4 == 0) ? $urandom : edgy();
      run("R2-R13 random", op, a, b, $urandom, 4'($urandom), -1, -1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule